// File: doc/BRIEF.md
# Key-Serviced Watchdog Timer

This block is a watchdog that runs from the oscillator clock alone. It has no other clock domain, so it keeps counting in standby while every other peripheral is stopped. An 8-bit up counter advances on ticks from a power-of-two prescaler. Software keeps the counter from running out by writing a two-byte key, 0x55 and then 0xAA, to the key register. If the counter is allowed to run out, the block produces a fixed 512-cycle active-low pulse.

A mode bit in the control register selects where that pulse goes. It can drive the reset output, which feeds the chip reset controller. It can instead drive the interrupt output, which can serve as a wakeup request for a low-power controller. Counting pauses while software has the timer disabled. It also pauses while the clock-valid input reports that the input clock has failed.

Top module: `wdog_timer`

## Requirements
- R1: With divide factor D, the selected output goes low at the 256*D-th rising clock edge after reset release or after a key clear. The count passes through 0..0xFF, and the prescaled tick that finds the count at 0xFF starts the pulse.
- R2: The pulse holds the selected output low for exactly 512 clock cycles. While it lasts, the count is held at zero and no new expiry can start. The next expiry follows 256*D edges after the pulse ends.
- R3: A key-register write (wr_sel = 0) of 0x55 followed by a key-register write of 0xAA clears the count and the prescaler on the 0xAA write edge.
- R4: A key write of any value other than 0xAA after 0x55 cancels the pending sequence. A key write of 0xAA with no pending 0x55 has no effect. A second 0x55 keeps the sequence armed. Control-register writes between the two key bytes do not disturb the sequence.
- R5: Control bit 0 (enable) low freezes the count and prevents expiry. Setting it high again resumes counting from the frozen value.
- R6: While clk_ok is low, the count and the prescaler hold their values.
- R7: Control bit 1 selects the pulse destination: 0 for rst_out_n, 1 for irq_out_n. The destination is captured at expiry, so a mode change during a pulse does not move or shorten it. The two outputs are never low together.
- R8: Control bits 4:2 hold a select value s, and the divide factor is D = 2^s. A select value of 7 behaves as 6, giving D = 64. A control write is made with wr_sel = 1.
- R9: After reset, both outputs are high, the timer is enabled in reset mode with D = 1 and the count at zero, and no key byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 for the key register, 1 for the control register |
| wr_data | input | 8 | Write data |
| clk_ok | input | 1 | High while the input clock is valid |
| rst_out_n | output | 1 | Expiry pulse in reset mode, active low |
| irq_out_n | output | 1 | Expiry pulse in interrupt mode, active low |

## Verification
The bench measures the time to expiry in clock edges in several situations, and each measurement tells a different fault apart:
- An untouched timer shows the base timeout and the pulse width.
- Periodic servicing shows that the key actually clears the count.
- Broken key orders (wrong second byte, lone 0xAA, doubled 0x55) separate a correct sequence tracker from one that clears too eagerly or forgets its arming.
- Disable windows and clock-fail windows of known length must add exactly their length to the timeout, which exposes a counter that leaks ticks or one that is reset instead of held.
- Two divide settings, 4 and the saturated 64, together with a mode switch made in the middle of a pulse, check the prescaler decode and the capture of the pulse destination at expiry.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  // Control register layout: enable at bit 0, mode at bit 1, divide select at 4:2
  typedef struct packed {
    logic [2:0] div_sel;
    logic       irq_mode;
    logic       enable;
  } wd_ctrl_t;

  localparam wd_ctrl_t WD_CTRL_RST = '{div_sel: 3'd0, irq_mode: 1'b0, enable: 1'b1};

  function automatic wd_ctrl_t wd_ctrl_decode(input logic [4:0] d);
    return wd_ctrl_t'(d);
  endfunction
endpackage

// File: rtl/wdog_keyseq.sv
`timescale 1ns/1ps
module wdog_keyseq #(
  parameter int          KW    = 8,
  parameter logic [KW-1:0] KEY_A = 8'h55,
  parameter logic [KW-1:0] KEY_B = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [KW-1:0] key_data,
  output logic          key_clr
);
  logic armed_q;

  // A clear happens only on KEY_B directly after KEY_A
  assign key_clr = key_wr && armed_q && (key_data == KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (key_wr) armed_q <= (key_data == KEY_A);
  end
endmodule

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
  parameter int MAX_LOG = 6,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sync_clr,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  logic [MAX_LOG-1:0] pre_q;
  logic [MAX_LOG-1:0] mask;

  // Low s bits set; selects above MAX_LOG saturate
  function automatic logic [MAX_LOG-1:0] div_mask(input logic [SEL_W-1:0] s);
    logic [MAX_LOG-1:0] m;
    for (int i = 0; i < MAX_LOG; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  assign mask = div_mask(div_sel);
  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (sync_clr) pre_q <= '0;
    else if (run)      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core #(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             irq_mode,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             pulse_active,
  output logic             pulse_irq
);
  localparam int               PW       = $clog2(PULSE_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [PW-1:0]    PLEN_TOP = PW'(PULSE_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    plen_q;
  logic             pulse_q, irq_q;

  assign expire       = tick && (cnt_q == CNT_MAX) && !pulse_q;
  assign cnt          = cnt_q;
  assign pulse_active = pulse_q;
  assign pulse_irq    = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clr || expire || pulse_q) cnt_q <= '0;
    else if (tick)                     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      plen_q  <= '0;
      irq_q   <= 1'b0;
    end else if (expire) begin
      pulse_q <= 1'b1;
      plen_q  <= PLEN_TOP;
      irq_q   <= irq_mode;
    end else if (pulse_q) begin
      if (plen_q == '0) pulse_q <= 1'b0;
      else              plen_q  <= plen_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer #(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 512,
  parameter int DW        = 8,
  parameter int MAX_LOG   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          clk_ok,
  output logic          rst_out_n,
  output logic          irq_out_n
);
  import wdog_pkg::*;

  wd_ctrl_t         ctrl_q;
  logic             en, run, tick, key_clr, expire, pulse_active, pulse_irq;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= WD_CTRL_RST;
    else if (wr_en && wr_sel)  ctrl_q <= wd_ctrl_decode(wr_data[4:0]);
  end

  assign en  = ctrl_q.enable;
  assign run = en && clk_ok && !pulse_active;

  wdog_keyseq #(.KW(DW), .KEY_A(DW'(8'h55)), .KEY_B(DW'(8'hAA))) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(wr_en && !wr_sel),
    .key_data(wr_data), .key_clr(key_clr));

  wdog_prescaler #(.MAX_LOG(MAX_LOG), .SEL_W(3)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .sync_clr(key_clr),
    .div_sel(ctrl_q.div_sel), .tick(tick));

  wdog_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(key_clr),
    .irq_mode(ctrl_q.irq_mode), .cnt(cnt), .expire(expire),
    .pulse_active(pulse_active), .pulse_irq(pulse_irq));

  assign rst_out_n = !(pulse_active && !pulse_irq);
  assign irq_out_n = !(pulse_active &&  pulse_irq);
endmodule

// File: rtl/wdog_checks.sv
`timescale 1ns/1ps
module wdog_checks #(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_ok,
  input logic             en,
  input logic             key_clr,
  input logic             expire,
  input logic             pulse_active,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_out_n,
  input logic             irq_out_n
);
  localparam int LW = $clog2(PULSE_LEN) + 2;
  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_len <= '0;
    else if (pulse_active) run_len <= run_len + 1'b1;
    else                   run_len <= '0;
  end

  p_from_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_active) |-> $past(cnt) == {CNT_W{1'b1}});
  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_active) |-> run_len == LW'(PULSE_LEN));
  p_zero_in_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active |=> cnt == '0);
  p_key_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_clr |=> cnt == '0);
  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !expire);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_ok && !key_clr && !pulse_active) |=> $stable(cnt));
  p_one_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n || irq_out_n);
  p_dest_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pulse_active) && pulse_active) |-> ($stable(rst_out_n) && $stable(irq_out_n)));
endmodule

bind wdog_timer wdog_checks #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .en(en), .key_clr(key_clr),
  .expire(expire), .pulse_active(pulse_active), .cnt(cnt),
  .rst_out_n(rst_out_n), .irq_out_n(irq_out_n));

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, clk_ok = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       rst_out_n, irq_out_n;
  longint     cyc = 0, c0 = 0;
  int         n_tests = 0, n_fail = 0;

  wdog_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .clk_ok(clk_ok), .rst_out_n(rst_out_n), .irq_out_n(irq_out_n));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 150000) begin
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, got %0d cycles expected under 150000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clk_ok = 1'b1; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; c0 = cyc;
  endtask

  // called at a negedge; the write takes effect at the next rising edge
  task automatic wr(input logic sel, input logic [7:0] d, output longint e);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; e = cyc;
  endtask

  task automatic wait_low(input int limit, output longint at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!rst_out_n || !irq_out_n) begin at = cyc; break; end
    end
  endtask

  task automatic pulse_meas(output int w_rst, output int w_irq, output longint end_at);
    w_rst = 0; w_irq = 0;
    while (!rst_out_n || !irq_out_n) begin
      if (!rst_out_n) w_rst++;
      if (!irq_out_n) w_irq++;
      @(negedge clk);
    end
    end_at = cyc;
  endtask

  task automatic t_reset_state();
    do_reset(); @(negedge clk);
    chk("R9 rst_out_n after reset", rst_out_n, 1);
    chk("R9 irq_out_n after reset", irq_out_n, 1);
  endtask

  task automatic t_default_timeout();
    longint at, e2, at2; int wr_, wi;
    do_reset();
    wait_low(2000, at);
    chk("R1 default timeout edges", at - c0, 256);
    pulse_meas(wr_, wi, e2);
    chk("R2 pulse width on reset output", wr_, 512);
    chk("R7 interrupt output idle in reset mode", wi, 0);
    wait_low(2000, at2);
    chk("R2 restart from zero after pulse", at2 - e2, 256);
  endtask

  task automatic t_service();
    longint e, at; int lows = 0;
    do_reset();
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (!rst_out_n) lows++; end
      wr(1'b0, 8'h55, e); wr(1'b0, 8'hAA, e);
    end
    chk("R3 serviced timer never fires", lows, 0);
    wait_low(2000, at);
    chk("R3 timeout counted from key clear", at - e, 256);
  endtask

  task automatic t_bad_keys();
    longint e, at;
    do_reset();
    repeat (100) @(negedge clk);
    wr(1'b0, 8'h55, e); wr(1'b0, 8'h12, e); wr(1'b0, 8'hAA, e);
    wr(1'b0, 8'hAA, e);
    wait_low(2000, at);
    chk("R4 broken and lone key bytes ignored", at - c0, 256);
    do_reset();
    repeat (50) @(negedge clk);
    wr(1'b0, 8'h55, e); wr(1'b0, 8'h55, e); wr(1'b0, 8'hAA, e);
    wait_low(2000, at);
    chk("R4 repeated 0x55 keeps sequence armed", at - e, 256);
    do_reset();
    repeat (50) @(negedge clk);
    wr(1'b0, 8'h55, e); wr(1'b1, 8'h01, e); wr(1'b0, 8'hAA, e);
    wait_low(2000, at);
    chk("R4 control write inside key sequence", at - e, 256);
  endtask

  task automatic t_disable();
    longint ed, ee, at, none;
    do_reset();
    repeat (100) @(negedge clk);
    wr(1'b1, 8'h00, ed);
    wait_low(600, none);
    chk("R5 disabled timer does not fire", none, -1);
    wr(1'b1, 8'h01, ee);
    wait_low(2000, at);
    chk("R5 count resumes from held value", at - c0, 256 + (ee - ed));
  endtask

  task automatic t_clk_fail();
    longint a, b, at, none;
    do_reset();
    repeat (100) @(negedge clk);
    clk_ok = 1'b0; a = cyc;
    wait_low(300, none);
    clk_ok = 1'b1; b = cyc;
    chk("R6 no expiry while clock failed", none, -1);
    wait_low(2000, at);
    chk("R6 count held while clock failed", at - c0, 256 + (b - a));
  endtask

  task automatic t_irq_mode();
    longint e, at, en_; int wr_, wi;
    do_reset();
    wr(1'b1, 8'h03, e);
    wr(1'b0, 8'h55, e); wr(1'b0, 8'hAA, e);
    wait_low(2000, at);
    chk("R7 interrupt mode timeout", at - e, 256);
    pulse_meas(wr_, wi, en_);
    chk("R7 interrupt pulse width", wi, 512);
    chk("R7 reset output idle in interrupt mode", wr_, 0);
  endtask

  task automatic t_mode_latch();
    longint e, at, en_; int wr_, wi;
    do_reset();
    wait_low(2000, at);
    wr(1'b1, 8'h03, e);
    pulse_meas(wr_, wi, en_);
    chk("R7 destination captured at expiry", wr_ + 1, 512);
    chk("R7 no interrupt from mode change mid-pulse", wi, 0);
  endtask

  task automatic t_prescale();
    longint e, at;
    do_reset();
    wr(1'b1, 8'h09, e);
    wr(1'b0, 8'h55, e); wr(1'b0, 8'hAA, e);
    wait_low(5000, at);
    chk("R8 divide by 4 timeout", at - e, 1024);
    do_reset();
    wr(1'b1, 8'h1D, e);
    wr(1'b0, 8'h55, e); wr(1'b0, 8'hAA, e);
    wait_low(20000, at);
    chk("R8 select 7 saturates at 64", at - e, 16384);
  endtask

  initial begin
    t_reset_state();
    t_default_timeout();
    t_service();
    t_bad_keys();
    t_disable();
    t_clk_fail();
    t_irq_mode();
    t_mode_latch();
    t_prescale();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule